// File: doc/BRIEF.md
# T1 Bit-Oriented Message Transceiver

This block carries short bit-oriented maintenance messages over the ESF facility data link. Each message is a 16-bit codeword that the block repeats for as long as it is sending. The codeword is eight ones, then a zero, then six payload bits with the most significant bit first, then a closing zero. Every other piece of logic handles the data-link slot timing. It sends this block one `slot_en` strobe per FDL bit. On each strobe the block drives one transmit bit and takes in one receive bit.

The transmitter copies `tx_msg` into a shadow register at the start of every codeword, so a codeword never mixes an old payload with a new one. Clearing `tx_enable` does not cut the current codeword short. The codeword finishes and the line then idles at one. This lets the controller pause messaging for a while so that message-oriented traffic can use the link.

The receiver hunts for eight or more ones followed by a zero and then collects the rest of the byte. It accepts the codeword only when the closing bit is zero. The payload is published on `rx_msg` only after the same payload has arrived in `CONFIRM` back-to-back valid codewords. This keeps a single corrupted codeword from appearing as a message. A one-cycle `rx_changed` pulse marks each new value.

Transmit FSM: `TX_IDLE` (line at one) moves to `TX_SEND` on a strobe while enabled. `TX_SEND` returns to `TX_IDLE` at a codeword boundary strobe while disabled, and otherwise stays in `TX_SEND` and reloads the shadow. Receive FSM: `RX_HUNT` moves to `RX_BODY` on a zero that follows at least eight ones. `RX_BODY` returns to `RX_HUNT` after the closing bit, whether that bit is valid or not.

Top module: `bom_xcvr`

## Requirements
- R1: After reset `tx_bit` is 1, `rx_msg` is 0 and `rx_changed` is 0.
- R2: While enabled, the transmitter sends bits in this order, one per strobe and repeated without gaps: positions 0 to 7 are 1, position 8 is 0, positions 9 to 14 are `tx_msg[5]` down to `tx_msg[0]`, and position 15 is 0.
- R3: The payload of a codeword is the value of `tx_msg` at that codeword's first strobe. Changes to `tx_msg` during a codeword first appear in the next codeword.
- R4: If `tx_enable` is low at a codeword boundary strobe, the current codeword has already been sent in full and `tx_bit` stays 1 from then on. A strobe with `tx_enable` high while idle starts a new codeword at position 0.
- R5: `tx_bit` and `rx_msg` change only on a clock edge where `slot_en` is high.
- R6: The receiver accepts a codeword made of at least eight ones, then 0, then six payload bits with the MSB first, then 0. The six payload bits are the message.
- R7: `rx_msg` takes a new payload only after that payload arrives in `CONFIRM` (default 2) consecutive valid codewords. A single valid codeword has no effect.
- R8: A codeword with a closing bit of 1, or a zero after fewer than eight ones, is rejected and restarts the consecutive count.
- R9: `rx_changed` is high for exactly one clock cycle when `rx_msg` takes a different value. A confirmed payload equal to the current `rx_msg` gives no pulse.
- R10: If a payload keeps repeating after it has been confirmed, `rx_changed` does not pulse again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | One-cycle strobe for each FDL bit slot |
| tx_enable | input | 1 | Enables codeword transmission |
| tx_msg | input | 6 | Payload of the transmitted message |
| tx_bit | output | 1 | Transmit FDL bit for the current slot |
| rx_bit | input | 1 | Receive FDL bit, sampled on a strobe |
| rx_msg | output | 6 | Last confirmed received payload |
| rx_changed | output | 1 | One-cycle pulse when `rx_msg` takes a new value |

## Verification
The bench changes `tx_msg` in the middle of codewords. A transmitter without a boundary shadow would then send a codeword that is half old payload and half new. It also drops `tx_enable` partway through a codeword. A design that stops at once would cut the codeword short, and one that ignores the enable would keep sending. On the receive side the bench sends a lone codeword, a codeword with a bad closing bit, and a codeword with only seven leading ones, each placed between good repeats. A receiver that does not confirm would publish noise, and one that does not clear its count on a rejected codeword would accept two repeats that are not adjacent. Confirmed repeats of the current value and long runs of the same payload check that a careless change flag does not pulse again.

// File: rtl/bom_pkg.sv
package bom_pkg;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
    typedef enum logic {RX_HUNT, RX_BODY} rx_state_e;
endpackage

// File: rtl/bom_tx.sv
module bom_tx
    import bom_pkg::*;
#(
    parameter int ONES_LEN = 8,
    parameter int PAY_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_en,
    input  logic             tx_enable,
    input  logic [PAY_W-1:0] tx_msg,
    output logic             tx_bit
);
    localparam int CW_LEN = ONES_LEN + PAY_W + 2;
    localparam int POS_W  = $clog2(CW_LEN);
    localparam logic [POS_W-1:0] P_ONE  = POS_W'(1);
    localparam logic [POS_W-1:0] P_SEP  = POS_W'(ONES_LEN);
    localparam logic [POS_W-1:0] P_LAST = POS_W'(CW_LEN - 1);

    tx_state_e        st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;   // position of the next bit to send
    logic [PAY_W-1:0] sh_q, sh_d;     // payload shadow, shifted out MSB first
    logic             bit_q, bit_d;

    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        sh_d  = sh_q;
        bit_d = bit_q;
        if (slot_en) begin
            unique case (st_q)
                TX_IDLE: begin
                    bit_d = 1'b1;
                    if (tx_enable) begin
                        st_d  = TX_SEND;
                        sh_d  = tx_msg;
                        pos_d = P_ONE;
                    end
                end
                TX_SEND: begin
                    if (pos_q == '0) begin
                        bit_d = 1'b1;
                        if (tx_enable) begin
                            sh_d  = tx_msg;
                            pos_d = P_ONE;
                        end else begin
                            st_d = TX_IDLE;
                        end
                    end else begin
                        pos_d = (pos_q == P_LAST) ? '0 : pos_q + P_ONE;
                        if (pos_q < P_SEP) begin
                            bit_d = 1'b1;
                        end else if (pos_q == P_SEP || pos_q == P_LAST) begin
                            bit_d = 1'b0;
                        end else begin
                            bit_d = sh_q[PAY_W-1];
                            sh_d  = {sh_q[PAY_W-2:0], 1'b0};
                        end
                    end
                end
                default: st_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            sh_q  <= '0;
            bit_q <= 1'b1;
        end else begin
            pos_q <= pos_d;
            sh_q  <= sh_d;
            bit_q <= bit_d;
        end
    end

    assign tx_bit = bit_q;

    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(tx_bit));
    a_r4_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_IDLE) |-> tx_bit);
    a_r2_ones_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_SEND && pos_q >= P_ONE && pos_q <= P_SEP) |-> tx_bit);
    a_r2_zero_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_SEND && (pos_q == '0 || pos_q == P_SEP + P_ONE)) |-> !tx_bit);
endmodule

// File: rtl/bom_rx.sv
module bom_rx
    import bom_pkg::*;
#(
    parameter int ONES_LEN = 8,
    parameter int PAY_W    = 6,
    parameter int CONFIRM  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_en,
    input  logic             rx_bit,
    output logic [PAY_W-1:0] rx_msg,
    output logic             rx_changed
);
    localparam int ONES_W = $clog2(ONES_LEN + 1);
    localparam int BCNT_W = $clog2(PAY_W + 1);
    localparam int RUN_W  = $clog2(CONFIRM + 1);
    localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(ONES_LEN);
    localparam logic [BCNT_W-1:0] BC_TAIL  = BCNT_W'(PAY_W);
    localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(CONFIRM);

    rx_state_e         st_q, st_d;
    logic [ONES_W-1:0] ones_q, ones_d;
    logic [BCNT_W-1:0] bc_q, bc_d;
    logic [PAY_W-1:0]  data_q, data_d;
    logic [PAY_W-1:0]  cand_q, cand_d;
    logic [RUN_W-1:0]  run_q, run_d;
    logic [PAY_W-1:0]  msg_q, msg_d;
    logic              chg_q, chg_d;
    logic              same;
    logic [RUN_W-1:0]  run_new;
    logic              reached;

    always_comb begin
        same    = (run_q != '0) && (data_q == cand_q);
        run_new = same ? ((run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1)) : RUN_W'(1);
        reached = (run_new == RUN_MAX) && !(same && run_q == RUN_MAX);
    end

    always_comb begin
        st_d   = st_q;
        ones_d = ones_q;
        bc_d   = bc_q;
        data_d = data_q;
        cand_d = cand_q;
        run_d  = run_q;
        msg_d  = msg_q;
        chg_d  = 1'b0;
        if (slot_en) begin
            unique case (st_q)
                RX_HUNT: begin
                    if (rx_bit) begin
                        ones_d = (ones_q == ONES_MAX) ? ones_q : ones_q + ONES_W'(1);
                    end else if (ones_q == ONES_MAX) begin
                        st_d   = RX_BODY;
                        ones_d = '0;
                        bc_d   = '0;
                    end else begin
                        ones_d = '0;
                        run_d  = '0;
                    end
                end
                RX_BODY: begin
                    if (bc_q == BC_TAIL) begin
                        st_d = RX_HUNT;
                        if (!rx_bit) begin
                            cand_d = data_q;
                            run_d  = run_new;
                            if (reached && data_q != msg_q) begin
                                msg_d = data_q;
                                chg_d = 1'b1;
                            end
                        end else begin
                            run_d = '0;
                        end
                    end else begin
                        data_d = {data_q[PAY_W-2:0], rx_bit};
                        bc_d   = bc_q + BCNT_W'(1);
                    end
                end
                default: st_d = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_HUNT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
            bc_q   <= '0;
            data_q <= '0;
            cand_q <= '0;
            run_q  <= '0;
            msg_q  <= '0;
            chg_q  <= 1'b0;
        end else begin
            ones_q <= ones_d;
            bc_q   <= bc_d;
            data_q <= data_d;
            cand_q <= cand_d;
            run_q  <= run_d;
            msg_q  <= msg_d;
            chg_q  <= chg_d;
        end
    end

    assign rx_msg     = msg_q;
    assign rx_changed = chg_q;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_changed |=> !rx_changed);
    a_r9_value_differs: assert property (@(posedge clk) disable iff (!rst_n)
        rx_changed |-> (rx_msg != $past(rx_msg)));
    a_r7_move_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_msg) |-> rx_changed);
    a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(rx_msg));
endmodule

// File: rtl/bom_xcvr.sv
module bom_xcvr #(
    parameter int ONES_LEN = 8,
    parameter int PAY_W    = 6,
    parameter int CONFIRM  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_en,
    input  logic             tx_enable,
    input  logic [PAY_W-1:0] tx_msg,
    output logic             tx_bit,
    input  logic             rx_bit,
    output logic [PAY_W-1:0] rx_msg,
    output logic             rx_changed
);
    bom_tx #(.ONES_LEN(ONES_LEN), .PAY_W(PAY_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .tx_enable (tx_enable),
        .tx_msg    (tx_msg),
        .tx_bit    (tx_bit)
    );

    bom_rx #(.ONES_LEN(ONES_LEN), .PAY_W(PAY_W), .CONFIRM(CONFIRM)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_en    (slot_en),
        .rx_bit     (rx_bit),
        .rx_msg     (rx_msg),
        .rx_changed (rx_changed)
    );
endmodule

// File: tb/bom_xcvr_tb_top.sv
module bom_xcvr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_en = 1'b0;
    logic       tx_enable = 1'b0;
    logic [5:0] tx_msg = '0;
    logic       tx_bit;
    logic       rx_bit = 1'b1;
    logic [5:0] rx_msg;
    logic       rx_changed;

    int checks = 0;
    int errors = 0;

    // expected receive-side model state
    logic [5:0] m_msg = '0;
    logic [5:0] m_cand = '0;
    int         m_run = 0;

    always #4 clk = ~clk;

    bom_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .tx_enable(tx_enable),
        .tx_msg(tx_msg), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .rx_msg(rx_msg), .rx_changed(rx_changed)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic cw_bit(input logic [5:0] m, input int p);
        logic [5:0] t;
        if (p < 8) return 1'b1;
        if (p == 8 || p == 15) return 1'b0;
        t = m >> (14 - p);
        return t[0];
    endfunction

    task automatic strobe(input logic b, output logic txb);
        @(negedge clk);
        rx_bit  = b;
        slot_en = 1'b1;
        @(negedge clk);
        slot_en = 1'b0;
        txb = tx_bit;
    endtask

    // kind 0: valid, 1: closing bit is 1, 2: only seven leading ones
    task automatic send_cw(input logic [5:0] pay, input int kind, input string tag);
        logic t;
        logic exp_chg;
        exp_chg = 1'b0;
        if (kind == 2) strobe(1'b0, t);
        for (int i = 0; i < 16; i++) begin
            logic b;
            b = cw_bit(pay, i);
            if (kind == 2 && i == 0) b = 1'b0;
            if (kind == 1 && i == 15) b = 1'b1;
            if (kind == 2 && i == 0) continue;
            strobe(b, t);
        end
        if (kind == 0) begin
            if (m_run > 0 && pay == m_cand) begin
                if (m_run < 2) begin
                    m_run++;
                    if (m_run == 2 && pay != m_msg) begin
                        m_msg = pay;
                        exp_chg = 1'b1;
                    end
                end
            end else begin
                m_cand = pay;
                m_run = 1;
            end
        end else begin
            m_run = 0;
        end
        chk({tag, " rx_changed"}, 32'(rx_changed), 32'(exp_chg));
        chk({tag, " rx_msg"}, 32'(rx_msg), 32'(m_msg));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic t;
        logic [5:0] pay;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx_bit", 32'(tx_bit), 32'd1);
        chk("R1 rx_msg", 32'(rx_msg), 32'd0);
        chk("R1 rx_changed", 32'(rx_changed), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: random payloads, tx_msg disturbed mid-codeword
        tx_enable = 1'b1;
        for (int c = 0; c < 12; c++) begin
            int disturb;
            pay = 6'($urandom);
            if (c == 0) pay = 6'h3f;
            if (c == 1) pay = 6'h00;
            tx_msg = pay;
            disturb = 1 + int'($urandom % 14);
            for (int i = 0; i < 16; i++) begin
                if (i == disturb) tx_msg = ~pay;
                strobe(1'b1, t);
                chk((i == disturb + 1) ? "R3 tx bit after change" : "R2 tx bit",
                    32'(t), 32'(cw_bit(pay, i)));
            end
        end

        // R5: no strobe, no change
        tx_msg = 6'h2a;
        strobe(1'b1, t);
        repeat (5) @(negedge clk);
        chk("R5 tx_bit held", 32'(tx_bit), 32'(t));
        chk("R5 rx_msg held", 32'(rx_msg), 32'd0);
        for (int i = 1; i < 16; i++) begin
            strobe(1'b1, t);
            if (i == 5) tx_enable = 1'b0;
            chk("R4 finish codeword", 32'(t), 32'(cw_bit(6'h2a, i)));
        end
        // R4: idle after the boundary
        for (int i = 0; i < 20; i++) begin
            strobe(1'b1, t);
            chk("R4 idle mark", 32'(t), 32'd1);
        end
        tx_enable = 1'b1;
        tx_msg = 6'h15;
        for (int i = 0; i < 16; i++) begin
            strobe(1'b1, t);
            chk("R4 restart codeword", 32'(t), 32'(cw_bit(6'h15, i)));
        end
        tx_enable = 1'b0;

        // receive directed cases
        send_cw(6'h2d, 0, "R7 single codeword");
        send_cw(6'h2d, 0, "R6 R9 confirmed");
        send_cw(6'h2d, 0, "R10 repeat");
        send_cw(6'h2d, 0, "R10 repeat again");
        send_cw(6'h12, 0, "R7 new first");
        send_cw(6'h12, 1, "R8 bad tail");
        send_cw(6'h12, 0, "R8 run restarted");
        send_cw(6'h12, 0, "R7 R9 confirmed");
        send_cw(6'h3f, 0, "R7 all ones first");
        send_cw(6'h3f, 2, "R8 short ones");
        send_cw(6'h3f, 0, "R8 run restarted");
        send_cw(6'h3f, 0, "R6 all ones confirmed");
        send_cw(6'h00, 0, "R7 zeros first");
        send_cw(6'h00, 0, "R6 zeros confirmed");
        send_cw(6'h3f, 0, "R9 other first");
        send_cw(6'h00, 0, "R9 back to current");
        send_cw(6'h00, 0, "R9 same value no pulse");

        // random receive traffic
        for (int c = 0; c < 60; c++) begin
            int k;
            int r;
            r = int'($urandom % 10);
            k = (r < 7) ? 0 : ((r < 9) ? 1 : 2);
            pay = (($urandom % 3) == 0) ? 6'($urandom) : m_cand;
            send_cw(pay, k, "R7 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule